// File: doc/BRIEF.md
# Serial Receiver Status Flag Logic

This block keeps the receive-side status flags of an asynchronous serial port. A receiver core feeds it one-cycle event strobes: a character-complete pulse with the received data and the sampled stop bit, a per-bit group of majority-vote samples, and a level that says the line is idle. The block also takes a wakeup-mode level and two bus read strobes, one for the status byte and one for the data byte. It holds the received character and five flags: receive full, idle, overrun, noise and framing error.

Every flag is cleared by a two-step sequence. First a status read is taken while the flag is set, which arms that flag for clearing. Then a later data read clears the armed flags. A data read on its own clears nothing. A flag that sets after the status read is not armed, so it survives the data read that follows. The idle flag sets once per idle period and needs line activity before it can set again. It is held off while the wakeup-mode level is high.

Top module: `srx_stat_top`

## Requirements
- R1: A character-complete pulse while receive full is clear loads the character into the data register and sets receive full; both show one cycle later.
- R2: A data read clears exactly those flags that were set at the most recent status read, and only if no data read came in between. A data read without a preceding status read clears no flag and leaves the data unchanged.
- R3: A flag that sets after the status read is not armed for clearing and stays set across the following data read.
- R4: A character-complete pulse while receive full is set, and not being cleared in that same cycle, sets overrun. The new character is dropped and the old one stays in the data register.
- R5: The noise flag sets when a character completes if any vote group with the valid strobe high since the previous character, including the group in the completing cycle, held samples that were not all equal.
- R6: The framing flag sets when a character completes with its stop bit sampled as 0.
- R7: The idle flag sets when the line-idle level is high and idle detection is armed. Setting the flag disarms detection, and only a cycle with line-idle low re-arms it. Detection is armed out of reset.
- R8: While the wakeup-mode level is high the idle flag cannot set, and detection stays armed.
- R9: Status byte layout: bit 5 receive full, bit 4 idle, bit 3 overrun, bit 2 noise, bit 1 framing. Bits 7, 6 and 0 always read 0.
- R10: Reset clears all flags, the clear arming and the data register to 0.
- R11: A data read that clears an armed receive full, in the same cycle as a character-complete pulse, loads the new character. Receive full stays set and overrun does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_done | input | 1 | Character complete strobe |
| chr_data | input | DATA_W | Received character, valid with chr_done |
| stop_smp | input | 1 | Sampled stop bit, valid with chr_done |
| vote_vld | input | 1 | Vote group valid strobe |
| vote_smp | input | VOTES | Samples of one bit |
| line_idle | input | 1 | Receive line idle level |
| wake_mode | input | 1 | Receiver wakeup mode level |
| stat_rd | input | 1 | Status byte read strobe |
| data_rd | input | 1 | Data byte read strobe |
| stat_byte | output | STAT_W | Status byte |
| data_byte | output | DATA_W | Held received character |

## Verification
The bench issues a data read with no status read before it. A design that lets the data read clear flags on its own would drop receive full at that point. It lets noise set between a status read and a data read: a design that clears every flag on the data read, instead of only the armed ones, loses the noise flag. It sends a second and a third character while receive full is set: a design that overwrites the data register shows the new character, and one that does not catch a read landing in the completing cycle raises a false overrun. It also holds the line idle across a clear and toggles wakeup mode: a design that re-arms without line activity, or ignores wakeup mode, sets idle at the wrong time.

// File: rtl/srx_stat_pkg.sv
package srx_stat_pkg;
   localparam int NUM_FLAGS = 5;
   localparam int F_FULL    = 0;
   localparam int F_IDLE    = 1;
   localparam int F_OVR     = 2;
   localparam int F_NOISE   = 3;
   localparam int F_FRAME   = 4;
endpackage

// File: rtl/srx_noise_acc.sv
module srx_noise_acc #(
   parameter int VOTES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vote_vld,
   input  logic [VOTES-1:0] vote_smp,
   input  logic             chr_done,
   output logic             noise_hit
);
   logic pend_q;
   logic noisy_now;

   generate
      if (VOTES < 1 || (VOTES % 2) == 0) begin : g_bad
         $error("VOTES must be odd and positive");
      end
      if (VOTES == 1) begin : g_single
         assign noisy_now = 1'b0;
      end else begin : g_multi
         assign noisy_now = vote_vld && (|vote_smp) && !(&vote_smp);
      end
   endgenerate

   assign noise_hit = pend_q | noisy_now;

   always_ff @(posedge clk) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (chr_done) pend_q <= 1'b0;
      else               pend_q <= noise_hit;
   end
endmodule

// File: rtl/srx_idle_arm.sv
module srx_idle_arm #(
   parameter bit ARM_AT_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_idle,
   input  logic wake_mode,
   output logic idle_set
);
   logic armed_q;

   assign idle_set = line_idle && armed_q && !wake_mode;

   generate
      if (ARM_AT_RESET) begin : g_arm_rst
         always_ff @(posedge clk) begin
            if (!rst_n)          armed_q <= 1'b1;
            else if (!line_idle) armed_q <= 1'b1;
            else if (idle_set)   armed_q <= 1'b0;
         end
      end else begin : g_disarm_rst
         always_ff @(posedge clk) begin
            if (!rst_n)          armed_q <= 1'b0;
            else if (!line_idle) armed_q <= 1'b1;
            else if (idle_set)   armed_q <= 1'b0;
         end
      end
   endgenerate

   // R7
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_set && line_idle) |=> !armed_q);
endmodule

// File: rtl/srx_flag_bank.sv
module srx_flag_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         stat_rd,
   input  logic         data_rd,
   output logic [N-1:0] flags,
   output logic [N-1:0] clr_vec
);
   logic [N-1:0] arm_q;

   generate
      if (N < 1) begin : g_bad
         $error("flag bank needs at least one flag");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         assign clr_vec[i] = data_rd && arm_q[i];

         always_ff @(posedge clk) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_vec[i]) flags[i] <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)       arm_q[i] <= 1'b0;
            else if (stat_rd) arm_q[i] <= flags[i];
            else if (data_rd) arm_q[i] <= 1'b0;
         end

         // R2
         fall_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(data_rd));
         // R3
         arm_in_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            arm_q[i] |-> flags[i]);
      end
   endgenerate
endmodule

// File: rtl/srx_stat_top.sv
module srx_stat_top #(
   parameter int DATA_W     = 8,
   parameter int STAT_W     = 8,
   parameter int VOTES      = 3,
   parameter int POS_FULL   = 5,
   parameter int POS_IDLE   = 4,
   parameter int POS_OVR    = 3,
   parameter int POS_NOISE  = 2,
   parameter int POS_FRAME  = 1,
   parameter bit IDLE_ARMED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chr_done,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              stop_smp,
   input  logic              vote_vld,
   input  logic [VOTES-1:0]  vote_smp,
   input  logic              line_idle,
   input  logic              wake_mode,
   input  logic              stat_rd,
   input  logic              data_rd,
   output logic [STAT_W-1:0] stat_byte,
   output logic [DATA_W-1:0] data_byte
);
   import srx_stat_pkg::*;

   localparam logic [STAT_W-1:0] POS_MASK =
      (STAT_W'(1) << POS_FULL) | (STAT_W'(1) << POS_IDLE) | (STAT_W'(1) << POS_OVR) |
      (STAT_W'(1) << POS_NOISE) | (STAT_W'(1) << POS_FRAME);

   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
      if (POS_FULL >= STAT_W || POS_IDLE >= STAT_W || POS_OVR >= STAT_W ||
          POS_NOISE >= STAT_W || POS_FRAME >= STAT_W) begin : g_bad_pos
         $error("flag position outside status byte");
      end
      if (POS_FULL == 0 || POS_IDLE == 0 || POS_OVR == 0 ||
          POS_NOISE == 0 || POS_FRAME == 0) begin : g_bad_zero
         $error("status bit 0 is reserved");
      end
      if ($countones(POS_MASK) != NUM_FLAGS) begin : g_bad_dup
         $error("flag positions must be distinct");
      end
   endgenerate

   logic                 noise_hit;
   logic                 idle_set;
   logic [NUM_FLAGS-1:0] set_vec;
   logic [NUM_FLAGS-1:0] flg;
   logic [NUM_FLAGS-1:0] clr_vec;
   logic                 full_free;
   logic                 load_chr;
   logic [DATA_W-1:0]    data_q;

   srx_noise_acc #(.VOTES(VOTES)) noise_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .vote_vld  (vote_vld),
      .vote_smp  (vote_smp),
      .chr_done  (chr_done),
      .noise_hit (noise_hit)
   );

   srx_idle_arm #(.ARM_AT_RESET(IDLE_ARMED)) idle_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_idle (line_idle),
      .wake_mode (wake_mode),
      .idle_set  (idle_set)
   );

   assign full_free = !flg[F_FULL] || clr_vec[F_FULL];
   assign load_chr  = chr_done && full_free;

   always_comb begin
      set_vec          = '0;
      set_vec[F_FULL]  = load_chr;
      set_vec[F_IDLE]  = idle_set;
      set_vec[F_OVR]   = chr_done && !full_free;
      set_vec[F_NOISE] = chr_done && noise_hit;
      set_vec[F_FRAME] = chr_done && !stop_smp;
   end

   srx_flag_bank #(.N(NUM_FLAGS)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .stat_rd (stat_rd),
      .data_rd (data_rd),
      .flags   (flg),
      .clr_vec (clr_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        data_q <= '0;
      else if (load_chr) data_q <= chr_data;
   end

   always_comb begin
      stat_byte            = '0;
      stat_byte[POS_FULL]  = flg[F_FULL];
      stat_byte[POS_IDLE]  = flg[F_IDLE];
      stat_byte[POS_OVR]   = flg[F_OVR];
      stat_byte[POS_NOISE] = flg[F_NOISE];
      stat_byte[POS_FRAME] = flg[F_FRAME];
   end

   assign data_byte = data_q;

   // R4
   overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_done && flg[F_FULL] && !data_rd) |=> (flg[F_OVR] && $stable(data_q)));
   // R6
   frame_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_done && !stop_smp) |=> flg[F_FRAME]);
   // R8
   idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg[F_IDLE]) |-> !$past(wake_mode));
   // R5
   noise_at_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg[F_NOISE]) |-> $past(chr_done));
   // R2
   clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_vec) |-> data_rd);
endmodule

// File: tb/srx_stat_top_tb_top.sv
`timescale 1ns/1ps
module srx_stat_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chr_done = 1'b0;
   logic [7:0] chr_data = 8'h00;
   logic       stop_smp = 1'b1;
   logic       vote_vld = 1'b0;
   logic [2:0] vote_smp = 3'b000;
   logic       line_idle = 1'b0;
   logic       wake_mode = 1'b0;
   logic       stat_rd = 1'b0;
   logic       data_rd = 1'b0;
   logic [7:0] stat_byte;
   logic [7:0] data_byte;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   srx_stat_top dut_i (
      .clk(clk), .rst_n(rst_n), .chr_done(chr_done), .chr_data(chr_data),
      .stop_smp(stop_smp), .vote_vld(vote_vld), .vote_smp(vote_smp),
      .line_idle(line_idle), .wake_mode(wake_mode), .stat_rd(stat_rd),
      .data_rd(data_rd), .stat_byte(stat_byte), .data_byte(data_byte)
   );

   // status bits: 20 full, 10 idle, 08 overrun, 04 noise, 02 framing
   function automatic logic [33:0] mk(input logic cd, input logic st, input logic vv,
                                      input logic [2:0] vs, input logic il, input logic wk,
                                      input logic sr, input logic dr, input logic [7:0] din,
                                      input logic [7:0] es, input logic [7:0] ed);
      return {cd, st, vv, vs, il, wk, sr, dr, din, es, ed};
   endfunction

   localparam int NV = 20;
   localparam logic [33:0] TBL [NV] = '{
      mk(1,1,0,3'b000,0,0,0,0,8'hA5, 8'h20,8'hA5), // R1 load
      mk(0,1,0,3'b000,0,0,0,1,8'h00, 8'h20,8'hA5), // R2 data read alone
      mk(0,1,0,3'b000,0,0,1,0,8'h00, 8'h20,8'hA5), // R2 status read
      mk(0,1,0,3'b000,0,0,0,1,8'h00, 8'h00,8'hA5), // R2 clear
      mk(1,0,0,3'b000,0,0,0,0,8'h3C, 8'h22,8'h3C), // R6 framing
      mk(1,1,0,3'b000,0,0,0,0,8'h77, 8'h2A,8'h3C), // R4 overrun keeps old
      mk(0,1,0,3'b000,0,0,1,0,8'h00, 8'h2A,8'h3C),
      mk(0,1,1,3'b101,0,0,0,0,8'h00, 8'h2A,8'h3C), // R5 noisy group pending
      mk(1,1,0,3'b000,0,0,0,0,8'h11, 8'h2E,8'h3C), // R5 noise at char, R4
      mk(0,1,0,3'b000,0,0,0,1,8'h00, 8'h04,8'h3C), // R3 noise survives
      mk(0,1,0,3'b000,0,0,1,0,8'h00, 8'h04,8'h3C),
      mk(0,1,0,3'b000,0,0,0,1,8'h00, 8'h00,8'h3C), // R3 later clear
      mk(1,1,1,3'b111,0,0,0,0,8'h5A, 8'h20,8'h5A), // R5 unanimous
      mk(0,1,0,3'b000,0,0,1,0,8'h00, 8'h20,8'h5A),
      mk(1,1,0,3'b000,0,0,0,1,8'hC3, 8'h20,8'hC3), // R11 read+char
      mk(0,1,0,3'b000,0,0,1,0,8'h00, 8'h20,8'hC3),
      mk(0,1,0,3'b000,0,0,0,1,8'h00, 8'h00,8'hC3),
      mk(1,1,1,3'b001,0,0,0,0,8'h99, 8'h24,8'h99), // R5 noise same cycle
      mk(0,1,0,3'b000,0,0,1,0,8'h00, 8'h24,8'h99),
      mk(0,1,0,3'b000,0,0,0,1,8'h00, 8'h00,8'h99)
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [33:0] v);
      @(negedge clk);
      {chr_done, stop_smp, vote_vld, vote_smp, line_idle, wake_mode,
       stat_rd, data_rd, chr_data} = v[33:16];
      @(negedge clk);
      chr_done = 1'b0; vote_vld = 1'b0; stat_rd = 1'b0; data_rd = 1'b0;
   endtask

   task automatic step(input string req, input logic [33:0] v);
      apply(v);
      chk({req, " status"}, stat_byte, v[15:8]);
      chk({req, " data"}, data_byte, v[7:0]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset status", stat_byte, 8'h00);
      chk("R10 reset data", data_byte, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step($sformatf("table row %0d", i), TBL[i]);
      end

      // R8 wake mode holds idle off
      step("R8 wake", mk(0,1,0,3'b000,1,1,0,0,8'h00, 8'h00,8'h99));
      // R7 idle sets once wake drops
      step("R7 idle set", mk(0,1,0,3'b000,1,0,0,0,8'h00, 8'h10,8'h99));
      step("R2 idle stat", mk(0,1,0,3'b000,1,0,1,0,8'h00, 8'h10,8'h99));
      step("R2 idle clear", mk(0,1,0,3'b000,1,0,0,1,8'h00, 8'h00,8'h99));
      step("R7 no rearm", mk(0,1,0,3'b000,1,0,0,0,8'h00, 8'h00,8'h99));
      step("R7 no rearm2", mk(0,1,0,3'b000,1,0,0,0,8'h00, 8'h00,8'h99));
      step("R7 activity", mk(0,1,0,3'b000,0,0,0,0,8'h00, 8'h00,8'h99));
      step("R7 rearmed", mk(0,1,0,3'b000,1,0,0,0,8'h00, 8'h10,8'h99));
      step("R6 R5 all", mk(1,0,1,3'b100,1,0,0,0,8'h42, 8'h36,8'h42));
      step("R9 R4 full set", mk(1,1,0,3'b000,1,0,0,0,8'h43, 8'h3E,8'h42));
      chk("R9 reserved bits", {stat_byte[7:6], 5'b0, stat_byte[0]}, 8'h00);
      step("R2 all stat", mk(0,1,0,3'b000,1,0,1,0,8'h00, 8'h3E,8'h42));
      step("R2 all clear", mk(0,1,0,3'b000,1,0,0,1,8'h00, 8'h00,8'h42));

      // R10 reset mid-run after setting flags
      step("R1 pre reset", mk(1,0,0,3'b000,0,0,0,0,8'h6E, 8'h22,8'h6E));
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R10 reset status again", stat_byte, 8'h00);
      chk("R10 reset data again", data_byte, 8'h00);

      finish_run();
   end
endmodule